// File: doc/BRIEF.md
# Double-Buffered Four-Channel Converter Code Bank

This block holds the digital codes for a four-channel, 8-bit converter. Each channel keeps two stages. An input stage captures a byte from a shared data bus when an active-low write strobe selects that channel through a 2-bit address. A second stage, the output stage, holds the code that the converter actually sees. One shared active-low load strobe copies all four input stages into their output stages together. Because of this, new codes can be staged channel by channel and then released at the same moment.

Both stages act as transparent latches, emulated inside one clock domain. While a strobe is low, its stage copies its source on every clock edge. When the strobe goes high, the stage keeps the value it took at the last edge that saw the strobe low. If write and load are low together, the addressed channel's output follows the bus directly in a single edge. The load strobe runs independently of write. When load is already low as write rises, load has to stay low for a parameterised number of cycles before it rises. Otherwise the new byte might not reach the output. A synchronous active-low reset clears every stage and is meant for test use.

Top module: `qdac_bank`

## Requirements
- R1: A clock edge with rst_n low clears all four input stages and all four output stages to 0x00.
- R2: A channel's output code comes only from its output stage. With ld_n high, no write changes any output code.
- R3: At every edge with wr_n low, the addressed channel's input stage takes the value of data. After wr_n rises, the stage keeps the value from the last edge at which wr_n was low.
- R4: At an edge with wr_n high, no input stage changes.
- R5: The address selects a channel as follows: 0 gives channel 0, 1 gives channel 1, 2 gives channel 2 and 3 gives channel 3. Only the addressed input stage responds to a write. Channel i drives dac_codes[8*i+7 : 8*i].
- R6: At an edge with ld_n high, no output stage changes. After ld_n rises, each output stage keeps the value it took at the last edge at which ld_n was low.
- R7: At an edge with ld_n low, every output stage takes the value its input stage holds after that edge.
- R8: At an edge with both wr_n and ld_n low, the addressed channel's output becomes data after that same edge. The other channels take their held input values.
- R9: Suppose wr_n rises at an edge while ld_n is low. Then ld_n must not rise until at least HOLD_CYC edges later. A simulation check flags any earlier rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples the strobes |
| rst_n | input | 1 | Synchronous active-low reset, used for test |
| wr_n | input | 1 | Active-low write strobe for the addressed input stage |
| ld_n | input | 1 | Active-low load strobe, shared by all four output stages |
| addr | input | 2 | Channel select for writes |
| data | input | 8 | Byte to be written |
| dac_codes | output | 32 | Four output codes; channel i occupies bits 8*i+7 down to 8*i |

## Verification
The write strobe and the load strobe can be active in the same cycle. In that cycle the addressed byte must pass through both stages in one edge, while the other channels take their held input values. The bench provokes this in two ways. Directed steps hold both strobes low on each channel. A swept pattern then lets the two low windows overlap at shifting addresses and data values. After every edge, all four output codes are compared against a two-stage model kept in the bench. Each overlap is released only after the required hold gap, and the gap itself is watched by a cycle counter.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
    localparam int unsigned QD_NCH   = 4;
    localparam int unsigned QD_W     = 8;
    localparam int unsigned QD_CNT_W = 16;

    typedef struct packed {
        logic                wr_prev;
        logic                ld_prev;
        logic                armed;
        logic [QD_CNT_W-1:0] gap;
    } hold_state_t;
endpackage

// File: rtl/qdac_in_stage.sv
module qdac_in_stage #(
    parameter int unsigned NCH = qdac_pkg::QD_NCH,
    parameter int unsigned W   = qdac_pkg::QD_W,
    localparam int unsigned AW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_n,
    input  logic [AW-1:0]         addr,
    input  logic [W-1:0]          data,
    output logic [NCH-1:0][W-1:0] in_q,
    output logic [NCH-1:0][W-1:0] in_d
);
    logic [NCH-1:0] sel;

    for (genvar i = 0; i < NCH; i++) begin : g_sel
        assign sel[i] = !wr_n && (addr == AW'(i));
    end

    always_comb begin
        in_d = in_q;
        for (int i = 0; i < NCH; i++) begin
            if (sel[i]) in_d[i] = data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) in_q <= '0;
        else        in_q <= in_d;
    end

    assert_in_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_n |=> $stable(in_q));

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        assert_in_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (!wr_n && addr == AW'(i)) |=> (in_q[i] == $past(data)));
        assert_in_other_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (addr != AW'(i)) |=> $stable(in_q[i]));
    end
endmodule

// File: rtl/qdac_out_stage.sv
module qdac_out_stage #(
    parameter int unsigned NCH = qdac_pkg::QD_NCH,
    parameter int unsigned W   = qdac_pkg::QD_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ld_n,
    input  logic [NCH-1:0][W-1:0] src,
    output logic [NCH-1:0][W-1:0] dac_q
);
    logic [NCH-1:0][W-1:0] dac_d;

    always_comb begin
        dac_d = dac_q;
        if (!ld_n) dac_d = src;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dac_q <= '0;
        else        dac_q <= dac_d;
    end

    assert_out_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ld_n |=> $stable(dac_q));
    assert_out_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_n |=> (dac_q == $past(src)));
endmodule

// File: rtl/qdac_hold_mon.sv
module qdac_hold_mon #(
    parameter int unsigned HOLD_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_n,
    input  logic ld_n,
    output logic hold_ok
);
    import qdac_pkg::*;

    hold_state_t st_q, st_d;
    logic wr_rise, ld_rise;

    assign wr_rise = wr_n && !st_q.wr_prev;
    assign ld_rise = ld_n && !st_q.ld_prev;
    assign hold_ok = !(wr_rise && !st_q.ld_prev)
                  && (!st_q.armed || (st_q.gap >= QD_CNT_W'(HOLD_CYC)));

    always_comb begin
        st_d         = st_q;
        st_d.wr_prev = wr_n;
        st_d.ld_prev = ld_n;
        if (wr_rise && !ld_n) begin
            st_d.armed = 1'b1;
            st_d.gap   = QD_CNT_W'(1);
        end else if (ld_n) begin
            st_d.armed = 1'b0;
            st_d.gap   = '0;
        end else if (st_q.armed && st_q.gap < QD_CNT_W'(HOLD_CYC)) begin
            st_d.gap = st_q.gap + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.wr_prev <= 1'b1;
            st_q.ld_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assert_load_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ld_rise |-> hold_ok);
endmodule

// File: rtl/qdac_bank.sv
module qdac_bank #(
    parameter int unsigned NCH      = qdac_pkg::QD_NCH,
    parameter int unsigned W        = qdac_pkg::QD_W,
    parameter int unsigned HOLD_CYC = 2,
    localparam int unsigned AW      = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_n,
    input  logic             ld_n,
    input  logic [AW-1:0]    addr,
    input  logic [W-1:0]     data,
    output logic [NCH*W-1:0] dac_codes
);
    logic [NCH-1:0][W-1:0] in_q, in_d, dac_q;
    logic                  hold_ok;

    qdac_in_stage #(.NCH(NCH), .W(W)) in_i (
        .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .addr(addr),
        .data(data), .in_q(in_q), .in_d(in_d)
    );

    qdac_out_stage #(.NCH(NCH), .W(W)) out_i (
        .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .src(in_d), .dac_q(dac_q)
    );

    qdac_hold_mon #(.HOLD_CYC(HOLD_CYC)) mon_i (
        .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .ld_n(ld_n), .hold_ok(hold_ok)
    );

    assign dac_codes = dac_q;

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        assert_pass_through_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (!wr_n && !ld_n && addr == AW'(i)) |=> (dac_codes[i*W +: W] == $past(data)));
        assert_out_input_R2: assert property (@(posedge clk) disable iff (!rst_n)
            !ld_n |=> (dac_q[i] == in_q[i]));
    end
endmodule

// File: tb/qdac_bank_tb_top.sv
module qdac_bank_tb_top;
    localparam int NCH = 4;
    localparam int W   = 8;
    localparam int HOLD = 2;

    logic clk = 1'b0;
    logic rst_n, wr_n, ld_n;
    logic [1:0] addr;
    logic [7:0] data;
    logic [NCH*W-1:0] dac_codes;

    logic [7:0] in_m  [NCH];
    logic [7:0] dac_m [NCH];
    int vectors = 0;
    int errors  = 0;

    always #2.5 clk = ~clk;

    qdac_bank #(.NCH(NCH), .W(W), .HOLD_CYC(HOLD)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .ld_n(ld_n),
        .addr(addr), .data(data), .dac_codes(dac_codes)
    );

    task automatic compare(input string tag);
        for (int c = 0; c < NCH; c++) begin
            vectors++;
            if (dac_codes[c*W +: W] !== dac_m[c]) begin
                errors++;
                $display("FAIL %s ch%0d actual=%02h expected=%02h",
                         tag, c, dac_codes[c*W +: W], dac_m[c]);
            end
        end
    endtask

    task automatic step(input logic r, input logic w, input logic l,
                        input logic [1:0] a, input logic [7:0] d,
                        input string tag);
        logic [7:0] nxt [NCH];
        @(negedge clk);
        rst_n = r; wr_n = w; ld_n = l; addr = a; data = d;
        @(posedge clk);
        for (int c = 0; c < NCH; c++) nxt[c] = in_m[c];
        if (!w) nxt[a] = d;
        for (int c = 0; c < NCH; c++) begin
            if (!r) begin
                in_m[c] = 8'h00; dac_m[c] = 8'h00;
            end else begin
                if (!l) dac_m[c] = nxt[c];
                in_m[c] = nxt[c];
            end
        end
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        #(5 * 200000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        for (int c = 0; c < NCH; c++) begin in_m[c] = 8'h00; dac_m[c] = 8'h00; end
        rst_n = 1'b0; wr_n = 1'b1; ld_n = 1'b1; addr = 2'd0; data = 8'h00;
        // R1: reset clears all outputs, also after a load of the cleared inputs
        step(1'b0, 1'b1, 1'b1, 2'd0, 8'h00, "R1 reset");
        step(1'b0, 1'b0, 1'b0, 2'd1, 8'hA5, "R1 reset dominates");
        step(1'b1, 1'b1, 1'b0, 2'd0, 8'h00, "R1 cleared inputs load");
        step(1'b1, 1'b1, 1'b1, 2'd0, 8'h00, "R1 idle");

        // R2 R5: writes with load high leave outputs untouched
        for (int c = 0; c < NCH; c++)
            step(1'b1, 1'b0, 1'b1, 2'(c), 8'(8'h11 * (c + 1)), "R2 R5 write only");
        step(1'b1, 1'b1, 1'b1, 2'd0, 8'hFF, "R4 write high");
        // R7: single load cycle moves all four, R6 then holds
        step(1'b1, 1'b1, 1'b0, 2'd0, 8'h00, "R7 load all");
        step(1'b1, 1'b1, 1'b1, 2'd3, 8'hEE, "R6 hold after load");

        // R3: several write cycles, last one wins
        step(1'b1, 1'b0, 1'b1, 2'd2, 8'h01, "R3 write first");
        step(1'b1, 1'b0, 1'b1, 2'd2, 8'h02, "R3 write second");
        step(1'b1, 1'b0, 1'b1, 2'd2, 8'h7E, "R3 write last");
        step(1'b1, 1'b1, 1'b1, 2'd2, 8'h99, "R4 bus ignored");
        step(1'b1, 1'b1, 1'b0, 2'd0, 8'h00, "R3 R7 load held");
        step(1'b1, 1'b1, 1'b1, 2'd0, 8'h00, "R6 hold");

        // R8: both low per channel, load kept low HOLD cycles after write rises
        for (int c = 0; c < NCH; c++) begin
            step(1'b1, 1'b1, 1'b0, 2'(c), 8'h00, "R7 load open");
            step(1'b1, 1'b0, 1'b0, 2'(c), 8'(8'hC3 ^ (c * 8'h1D)), "R8 pass through");
            for (int h = 0; h < HOLD; h++)
                step(1'b1, 1'b1, 1'b0, 2'(c), 8'h00, "R9 hold window");
            step(1'b1, 1'b1, 1'b1, 2'(c), 8'h00, "R6 close");
        end

        // R2 R5 R7: data sweep per channel
        for (int c = 0; c < NCH; c++) begin
            for (int v = 0; v < 256; v += 17) begin
                step(1'b1, 1'b0, 1'b1, 2'(c), 8'(v), "R2 R5 sweep write");
                step(1'b1, 1'b1, 1'b0, 2'(c), 8'(~v), "R7 sweep load");
                step(1'b1, 1'b1, 1'b1, 2'(c), 8'(v + 3), "R6 sweep hold");
            end
        end

        // R8 R9: overlapping strobe windows
        for (int k = 0; k < 512; k++) begin
            logic [8:0] kk;
            logic w, l;
            kk = 9'(k);
            l = kk[4];
            w = (kk[1:0] != 2'd0) || (kk[3:0] >= 4'd12);
            step(1'b1, w, l, kk[3:2] ^ kk[6:5], 8'(k * 37 + 5), "R8 overlap sweep");
        end

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule